// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Bank

This block is a 32-pin general-purpose I/O controller that sits behind a simple single-cycle register bus with an address, a write enable, write data and combinational read data. Offsets are decoded relative to the block's own base. The block keeps four pieces of state: an output data word, an output-enable word, a synchronized input word and a sticky per-pin event word.

Software can change the output data in five ways. It can write the whole word. It can set, clear or toggle selected bits by writing ones to a strobe register. It can also write single pins through alias words, each of which places four consecutive pins in the four byte lanes. The output data and output enables go to an external pad model. Each pin is driven only where its enable bit is 1. Event pulses come from an external edge-detection unit. Each pulse sets a bit that stays set until software writes a 1 to that bit.

Top module: `gpio_bank`

## Requirements
- R1: After reset, the output data, output enables, input capture and event words are all zero, and `padOut`, `padOe` and every readable offset read as zero.
- R2: A write to offset 0x80 loads all 32 output data bits from the write data in the next cycle. A read of 0x80 returns the output data.
- R3: A write to offset 0x90 sets every output data bit whose write-data bit is 1 and leaves the other bits unchanged.
- R4: A write to offset 0xA0 clears every output data bit whose write-data bit is 1 and leaves the other bits unchanged.
- R5: A write to offset 0xB0 inverts every output data bit whose write-data bit is 1 and leaves the other bits unchanged.
- R6: Alias word k sits at offset 4*k for k = 0 to 7. A write to it loads pin 4k+j from write-data bit 8*j, for j = 0 to 3, and changes no other output data bit. A read of it returns those four pins in bits 0, 8, 16 and 24.
- R7: All alias-word bits other than 0, 8, 16 and 24 read as zero, and writing to them has no effect.
- R8: Offset 0xD0 is the read/write output-enable word and drives `padOe`. `padOut` carries an output data bit only where that pin's enable bit is 1, and is 0 elsewhere.
- R9: A read of offset 0xC0 returns the pin levels on `padIn`. They pass through two synchronizer flops and a capture flop, so a change on `padIn` becomes visible after the third rising clock edge.
- R10: An event bit at offset 0xE0 becomes 1 in the cycle after its `evtPulse` bit is high, and then stays 1. Writing a 1 to the bit clears it. Writing a 0 leaves it unchanged.
- R11: When an event pulse and a clearing write hit the same event bit in the same cycle, the bit stays 1.
- R12: Reads of the set (0x90), clear (0xA0) and toggle (0xB0) offsets, and of any unmapped offset, return zero. Writes to unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Byte offset from the block base |
| busWe | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data for `busAddr` |
| padIn | input | 32 | Pin levels from the pad model |
| evtPulse | input | 32 | Per-pin event pulses from the edge-detection unit |
| padOut | output | 32 | Pin output values, masked by the enables |
| padOe | output | 32 | Pin output enables |

## Verification
The output-data path is driven by a seeded random mix of full writes, set, clear and toggle strobes, and alias writes. After each operation the bench reads the word back and compares it with a bench model. Random masks over a varied data word show whether each write form touches only the bits it selects. Alias writes use all-ones data, so that a reserved bit leaking into a pin is caught, and single-lane data, so that a swapped lane is caught. Directed cases cover three things: the exact cycle in which the input capture changes, a pulse colliding with a clearing write on the same event bit, and reads of strobe and unmapped offsets.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int PINS = 32;
  localparam int DATA_W = 32;
  localparam int LANES = 4;
  localparam int LANE_W = DATA_W / LANES;
  localparam int ALIAS_WORDS = PINS / LANES;
  localparam int ALIAS_IDX_W = $clog2(ALIAS_WORDS);
  localparam int LANE_IDX_W = $clog2(LANES);

  localparam logic [7:0] OFF_DATA = 8'h80;
  localparam logic [7:0] OFF_SET  = 8'h90;
  localparam logic [7:0] OFF_CLR  = 8'hA0;
  localparam logic [7:0] OFF_TGL  = 8'hB0;
  localparam logic [7:0] OFF_IN   = 8'hC0;
  localparam logic [7:0] OFF_OE   = 8'hD0;
  localparam logic [7:0] OFF_EVT  = 8'hE0;

  typedef enum logic [2:0] {
    RD_ZERO, RD_ALIAS, RD_DATA, RD_IN, RD_OE, RD_EVT
  } rdSel_e;

  typedef struct packed {
    logic wrAlias;
    logic wrData;
    logic wrSet;
    logic wrClr;
    logic wrTgl;
    logic wrOe;
    logic wrEvt;
    logic [ALIAS_IDX_W-1:0] aliasIdx;
    rdSel_e rdSel;
  } strobes_t;
endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output strobes_t          strobes
);
  localparam int ALIAS_SPAN_W = ALIAS_IDX_W + 2;

  logic isAlias;
  logic [7:0] offset;

  assign offset = 8'(busAddr);
  assign isAlias = (busAddr[ADDR_W-1:ALIAS_SPAN_W] == '0) && (busAddr[1:0] == 2'b00);

  always_comb begin
    strobes = '0;
    strobes.rdSel = RD_ZERO;
    strobes.aliasIdx = busAddr[ALIAS_SPAN_W-1:2];
    if (isAlias) begin
      strobes.wrAlias = busWe;
      strobes.rdSel = RD_ALIAS;
    end else begin
      unique case (offset)
        OFF_DATA: begin strobes.wrData = busWe; strobes.rdSel = RD_DATA; end
        OFF_SET:  strobes.wrSet = busWe;
        OFF_CLR:  strobes.wrClr = busWe;
        OFF_TGL:  strobes.wrTgl = busWe;
        OFF_IN:   strobes.rdSel = RD_IN;
        OFF_OE:   begin strobes.wrOe = busWe; strobes.rdSel = RD_OE; end
        OFF_EVT:  begin strobes.wrEvt = busWe; strobes.rdSel = RD_EVT; end
        default:  strobes.rdSel = RD_ZERO;
      endcase
    end
  end
endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [PINS-1:0]   padIn,
  input  logic [PINS-1:0]   evtPulse,
  output logic [PINS-1:0]   outData,
  output logic [PINS-1:0]   oeReg,
  output logic [PINS-1:0]   evtReg
);
  logic [PINS-1:0] syncA, syncB, inReg;
  logic [PINS-1:0] nextData;
  logic [PINS-1:0] evtClr;
  logic [DATA_W-1:0] aliasView;

  // Next output data from the one write form active this cycle
  always_comb begin
    nextData = outData;
    if (strobes.wrData) nextData = busWdata[PINS-1:0];
    else if (strobes.wrSet) nextData = outData | busWdata[PINS-1:0];
    else if (strobes.wrClr) nextData = outData & ~busWdata[PINS-1:0];
    else if (strobes.wrTgl) nextData = outData ^ busWdata[PINS-1:0];
    else if (strobes.wrAlias) begin
      for (int j = 0; j < LANES; j++)
        nextData[{strobes.aliasIdx, LANE_IDX_W'(j)}] = busWdata[j*LANE_W];
    end
  end

  // Alias read view: one pin at the bottom of each byte lane
  always_comb begin
    aliasView = '0;
    for (int j = 0; j < LANES; j++)
      aliasView[j*LANE_W] = outData[{strobes.aliasIdx, LANE_IDX_W'(j)}];
  end

  assign evtClr = strobes.wrEvt ? busWdata[PINS-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= '0;
      syncB   <= '0;
      inReg   <= '0;
      outData <= '0;
      oeReg   <= '0;
      evtReg  <= '0;
    end else begin
      syncA   <= padIn;
      syncB   <= syncA;
      inReg   <= syncB;
      outData <= nextData;
      if (strobes.wrOe) oeReg <= busWdata[PINS-1:0];
      evtReg  <= (evtReg & ~evtClr) | evtPulse;  // new event beats clear
    end
  end

  always_comb begin
    unique case (strobes.rdSel)
      RD_ALIAS: busRdata = aliasView;
      RD_DATA:  busRdata = DATA_W'(outData);
      RD_IN:    busRdata = DATA_W'(inReg);
      RD_OE:    busRdata = DATA_W'(oeReg);
      RD_EVT:   busRdata = DATA_W'(evtReg);
      default:  busRdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [31:0]       padIn,
  input  logic [31:0]       evtPulse,
  output logic [31:0]       padOut,
  output logic [31:0]       padOe
);
  strobes_t strobes;
  logic [PINS-1:0] outData, oeReg, evtReg;

  gpio_bank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr(busAddr), .busWe(busWe), .strobes(strobes)
  );

  gpio_bank_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busWdata(busWdata),
    .busRdata(busRdata), .padIn(padIn), .evtPulse(evtPulse),
    .outData(outData), .oeReg(oeReg), .evtReg(evtReg)
  );

  assign padOe  = oeReg;
  assign padOut = outData & oeReg;
endmodule

// File: rtl/gpio_bank_checker.sv
module gpio_bank_checker (
  input logic        clk,
  input logic        rstN,
  input logic [7:0]  busAddr,
  input logic        busWe,
  input logic [31:0] busWdata,
  input logic [31:0] busRdata,
  input logic [31:0] evtPulse,
  input logic [31:0] padOut,
  input logic [31:0] padOe,
  input logic [31:0] outData,
  input logic [31:0] evtReg
);
  assert_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == 8'h90) |=> ((outData & $past(busWdata)) == $past(busWdata)));

  assert_clr_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == 8'hA0) |=> ((outData & $past(busWdata)) == 32'h0));

  assert_tgl_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == 8'hB0) |=> (outData == ($past(outData) ^ $past(busWdata))));

  assert_pad_mask_R8: assert property (@(posedge clk) disable iff (!rstN)
    (padOut & ~padOe) == 32'h0);

  assert_evt_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(busWe && busAddr == 8'hE0) |=> ((evtReg & $past(evtReg)) == $past(evtReg)));

  assert_evt_wins_R11: assert property (@(posedge clk) disable iff (!rstN)
    (evtPulse != 32'h0) |=> ((evtReg & $past(evtPulse)) == $past(evtPulse)));

  assert_rd_zero_R12: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 8'h90 || busAddr == 8'hA0 || busAddr == 8'hB0 || busAddr == 8'hF0)
      |-> (busRdata == 32'h0));
endmodule

bind gpio_bank gpio_bank_checker u_checker (
  .clk(clk), .rstN(rstN), .busAddr(8'(busAddr)), .busWe(busWe),
  .busWdata(busWdata), .busRdata(busRdata), .evtPulse(evtPulse),
  .padOut(padOut), .padOe(padOe), .outData(outData), .evtReg(evtReg)
);

// File: tb/gpio_bank_bench.sv
`timescale 1ns/1ps
module gpio_bank_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] busAddr = '0;
  logic busWe = 1'b0;
  logic [31:0] busWdata = '0, busRdata, padIn = '0, evtPulse = '0, padOut, padOe;

  int checks = 0;
  int errors = 0;
  logic finished = 1'b0;
  logic [31:0] expData = '0, expOe = '0, expEvt = '0;

  always #10 clk = ~clk;

  gpio_bank u_gpio_bank (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn),
    .evtPulse(evtPulse), .padOut(padOut), .padOe(padOe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWe = 1'b1; busWdata = d;
    @(posedge clk);
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  function automatic logic [31:0] aliasApply(input logic [31:0] cur, input int k, input logic [31:0] d);
    logic [31:0] r = cur;
    for (int j = 0; j < 4; j++) r[4*k+j] = d[8*j];
    return r;
  endfunction

  function automatic logic [31:0] aliasView(input logic [31:0] cur, input int k);
    logic [31:0] r = '0;
    for (int j = 0; j < 4; j++) r[8*j] = cur[4*k+j];
    return r;
  endfunction

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    logic [31:0] rd, d;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1 reset state
    check("R1 padOut", padOut, 32'h0);
    check("R1 padOe", padOe, 32'h0);
    foreach (d[i]) ; // no-op
    busRead(8'h80, rd); check("R1 data", rd, 32'h0);
    busRead(8'hC0, rd); check("R1 input", rd, 32'h0);
    busRead(8'hD0, rd); check("R1 oe", rd, 32'h0);
    busRead(8'hE0, rd); check("R1 evt", rd, 32'h0);
    busRead(8'h0C, rd); check("R1 alias", rd, 32'h0);

    // R2 full write
    busWrite(8'h80, 32'hA5C3_0F96); expData = 32'hA5C3_0F96;
    busRead(8'h80, rd); check("R2 data", rd, expData);

    // R6/R7 alias with all ones and single lanes
    busWrite(8'h80, 32'h0);
    expData = 0;
    busWrite(8'h08, 32'hFFFF_FFFF); expData = aliasApply(expData, 2, 32'hFFFF_FFFF);
    busRead(8'h80, rd); check("R7 alias all-ones touches only pins 8..11", rd, 32'h0000_0F00);
    busRead(8'h08, rd); check("R7 alias reserved read zero", rd, 32'h0101_0101);
    busWrite(8'h1C, 32'h0001_0000); expData = aliasApply(expData, 7, 32'h0001_0000);
    busRead(8'h80, rd); check("R6 alias lane2 -> pin 30", rd, 32'h4000_0F00);
    busWrite(8'h08, 32'hFEFE_FEFE); expData = aliasApply(expData, 2, 32'hFEFE_FEFE);
    busRead(8'h80, rd); check("R7 reserved-only write clears lanes", rd, 32'h4000_0000);

    // R12 strobe and unmapped reads, unmapped write
    busRead(8'h90, rd); check("R12 set reads zero", rd, 32'h0);
    busRead(8'hA0, rd); check("R12 clr reads zero", rd, 32'h0);
    busRead(8'hB0, rd); check("R12 tgl reads zero", rd, 32'h0);
    busRead(8'h84, rd); check("R12 unmapped reads zero", rd, 32'h0);
    busWrite(8'h84, 32'hFFFF_FFFF);
    busWrite(8'hF0, 32'hFFFF_FFFF);
    busRead(8'h80, rd); check("R12 unmapped write no effect", rd, expData);

    // Random mix of output-data writes
    for (int n = 0; n < 300; n++) begin
      int op = int'($urandom_range(0, 4));
      d = $urandom;
      case (op)
        0: begin busWrite(8'h80, d); expData = d; busRead(8'h80, rd); check("R2 rand", rd, expData); end
        1: begin busWrite(8'h90, d); expData |= d; busRead(8'h80, rd); check("R3 rand set", rd, expData); end
        2: begin busWrite(8'hA0, d); expData &= ~d; busRead(8'h80, rd); check("R4 rand clr", rd, expData); end
        3: begin busWrite(8'hB0, d); expData ^= d; busRead(8'h80, rd); check("R5 rand tgl", rd, expData); end
        default: begin
          int k = int'($urandom_range(0, 7));
          busWrite(8'(4*k), d); expData = aliasApply(expData, k, d);
          busRead(8'(4*k), rd); check("R6 rand alias read", rd, aliasView(expData, k));
          busRead(8'h80, rd); check("R6 rand alias data", rd, expData);
        end
      endcase
    end

    // R8 output enable masking
    expOe = 32'hFFFF_0000;
    busWrite(8'hD0, expOe);
    busRead(8'hD0, rd); check("R8 oe read", rd, expOe);
    check("R8 padOe", padOe, expOe);
    check("R8 padOut masked", padOut, expData & expOe);
    expOe = $urandom; busWrite(8'hD0, expOe);
    check("R8 padOut random mask", padOut, expData & expOe);

    // R9 input synchronizer latency
    @(negedge clk); padIn = 32'hDEAD_BEEF;
    @(posedge clk); @(posedge clk);
    #1 busAddr = 8'hC0; #1 check("R9 not yet after two edges", busRdata, 32'h0);
    @(posedge clk); #1 check("R9 visible after third edge", busRdata, 32'hDEAD_BEEF);

    // R10 events
    @(negedge clk); evtPulse = 32'h0000_8001;
    @(negedge clk); evtPulse = '0; expEvt = 32'h0000_8001;
    busRead(8'hE0, rd); check("R10 evt set", rd, expEvt);
    repeat (3) @(posedge clk);
    busRead(8'hE0, rd); check("R10 evt sticky", rd, expEvt);
    busWrite(8'hE0, 32'hFFFF_7FFE);
    busRead(8'hE0, rd); check("R10 write zero keeps", rd, expEvt);
    busWrite(8'hE0, 32'h0000_0001); expEvt = 32'h0000_8000;
    busRead(8'hE0, rd); check("R10 w1c", rd, expEvt);

    // R11 pulse and clear collide on bit 15
    @(negedge clk);
    busAddr = 8'hE0; busWe = 1'b1; busWdata = 32'h0000_8000; evtPulse = 32'h0000_8000;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0; evtPulse = '0;
    busRead(8'hE0, rd); check("R11 event wins over clear", rd, 32'h0000_8000);

    finished = 1'b1;
    report();
  end
endmodule